// File: doc/BRIEF.md
# Timer-Triggered Capture Logger with Zero Suppression

This block records a stream of 32-bit words into an on-chip capture queue. The recording window opens at a programmable point in time. A free-running 32-bit tick counter restarts at every reset of the observed bus, which is also this block's reset. It counts once per clock. When the count equals the programmed trigger value, the window opens and stays open until the next reset. Each stored entry packs the data word with the low bits of the tick count at which the word was sampled. A reader can therefore place entries in time and see where words were left out.

A longer stretch of traffic is covered by repeating the capture with a later trigger each time and joining the traces. An optional filter mode drops words that are entirely zero, so idle bus cycles take no storage. A host drains the queue through a show-ahead read port: the oldest entry is always visible, and one strobe removes it. An occupancy output reports how full the queue is. When the queue fills, capture stops for good and a sticky flag is raised.

Top module: `capture_logger`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears itself. After that edge `occupancy` is 0, `rd_empty` is 1, and both `full_flag` and `capture_active` are 0.
- R2: The tick counter is 0 in the first cycle after reset and increases by one each cycle. No word presented in a cycle where the count is below the trigger value is stored.
- R3: The word presented in the cycle where the count equals `trig_value` is stored. `capture_active` rises in the following cycle.
- R4: A trigger value of 0 stores the word presented in the first cycle after reset.
- R5: Once `capture_active` is set, it stays set until reset. Later changes to `trig_value` neither stop capture nor fire a second trigger.
- R6: Each entry is 36 bits. Bits 31:0 hold the data word. Bits 35:32 hold bits 3:0 of the tick count in the cycle the word was presented.
- R7: When `skip_zero` is 1, an all-zero word is not stored and non-zero words are stored. When `skip_zero` is 0, zero words are stored like any other word.
- R8: `rd_data` shows the oldest stored entry, and entries leave in arrival order. A `rd_strobe` in a cycle with occupancy 0 has no effect.
- R9: `occupancy` equals writes minus pops. A write and a pop in the same cycle leave it unchanged.
- R10: When a write brings occupancy to the queue depth, `full_flag` goes high. It stays high until reset, and no further word is stored even after the queue is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the tick counter |
| trig_value | input | 32 | Tick count at which capture starts |
| skip_zero | input | 1 | 1 = drop all-zero words |
| in_valid | input | 1 | A data word is present this cycle |
| in_data | input | 32 | Sampled data word |
| rd_strobe | input | 1 | Remove the oldest entry |
| rd_data | output | 36 | Oldest entry: {stamp[3:0], data[31:0]} |
| rd_empty | output | 1 | Queue holds no entry |
| occupancy | output | $clog2(DEPTH)+1 | Number of stored entries |
| full_flag | output | 1 | Sticky: queue filled, capture halted |
| capture_active | output | 1 | Trigger has fired since reset |

## Verification
A capture write and a host pop can fall in the same cycle. The bench provokes this with a trigger value of 0: it stores two words, then presents a third word together with a read strobe. It judges the result by checking that occupancy does not change and that the read port then shows the second word. The trigger match can also coincide with the first stored word. Per-cycle checks of `capture_active` and occupancy around the trigger count confirm that the matching word is stored while the flag rises only one cycle later.

// File: rtl/capture_pkg.sv
// capture_pkg: default sizes shared by the capture logger modules.
// Assumes: depth is a power of two and the stamp field is narrower than the tick counter.
package capture_pkg;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_TAG_W  = 4;
    localparam int unsigned DEF_CNT_W  = 32;
    localparam int unsigned DEF_DEPTH  = 2048;
endpackage

// File: rtl/capture_timer.sv
// capture_timer: free-running tick counter restarted by reset, compared with a
// trigger value. The first match opens the capture window, which then stays open
// until reset. Also supplies the low tick bits used as the entry stamp.
// Assumes: TAG_W <= CNT_W; the trigger may change at any time.
module capture_timer #(
    parameter int CNT_W = capture_pkg::DEF_CNT_W,
    parameter int TAG_W = capture_pkg::DEF_TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] trig_value,
    output logic             trig_hit,
    output logic             window_open,
    output logic             armed,
    output logic [TAG_W-1:0] stamp
);
    logic [CNT_W-1:0] tick;

    // Count clock cycles since the last reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= '0;
        else        tick <= tick + 1'b1;
    end

    // A match only counts while the window is still closed.
    always_comb trig_hit = !armed && (tick == trig_value);

    // Latch the first match; it is cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b0;
        else if (trig_hit) armed <= 1'b1;
    end

    // The window covers the match cycle itself and all later cycles.
    always_comb window_open = armed || trig_hit;

    // The stamp is the low part of the current tick.
    always_comb stamp = tick[TAG_W-1:0];
endmodule

// File: rtl/capture_gate.sv
// capture_gate: decides whether the presented word is stored and builds the
// entry {stamp, data}. ZERO_FILTER selects whether the all-zero drop logic exists.
// Assumes: store_blocked covers every reason the queue cannot accept data.
module capture_gate #(
    parameter int DATA_W      = capture_pkg::DEF_DATA_W,
    parameter int TAG_W       = capture_pkg::DEF_TAG_W,
    parameter bit ZERO_FILTER = 1'b1,
    localparam int ENTRY_W    = DATA_W + TAG_W
) (
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               skip_zero,
    input  logic               window_open,
    input  logic               store_blocked,
    input  logic [TAG_W-1:0]   stamp,
    output logic               wr_en,
    output logic [ENTRY_W-1:0] wr_entry
);
    logic drop_word;

    generate
        if (ZERO_FILTER) begin : g_filter
            // Drop all-zero words when the filter mode is selected.
            always_comb drop_word = skip_zero && (in_data == '0);
        end else begin : g_nofilter
            // The filter is not built; every word passes.
            always_comb drop_word = 1'b0;
        end
    endgenerate

    // Store only valid, wanted words inside the window while space remains.
    always_comb wr_en = in_valid && window_open && !drop_word && !store_blocked;

    // Pack the stamp above the data word.
    always_comb wr_entry = {stamp, in_data};
endmodule

// File: rtl/capture_fifo.sv
// capture_fifo: storage queue with a show-ahead read port, an occupancy count and
// a sticky full flag. Once full, it accepts no more writes until reset.
// Assumes: DEPTH is a power of two; reading an empty queue is ignored.
module capture_fifo #(
    parameter int WIDTH   = capture_pkg::DEF_DATA_W + capture_pkg::DEF_TAG_W,
    parameter int DEPTH   = capture_pkg::DEF_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int OCC_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_strobe,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic [OCC_W-1:0] occupancy,
    output logic             full_sticky
);
    localparam logic [OCC_W-1:0] DEPTH_V = OCC_W'(DEPTH);

    logic [WIDTH-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic              push, pop;

    // Accept a write only while not full; pop only when an entry exists.
    always_comb begin
        push = wr_en && !full_sticky && (occupancy != DEPTH_V);
        pop  = rd_strobe && (occupancy != '0);
    end

    // Write the entry into storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    // Advance the pointers; they wrap naturally with a power-of-two depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Track occupancy; a push and a pop together cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)            occupancy <= '0;
        else if (push && !pop) occupancy <= occupancy + 1'b1;
        else if (pop && !push) occupancy <= occupancy - 1'b1;
    end

    // Raise the sticky flag when a write fills the last free slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          full_sticky <= 1'b0;
        else if (push && !pop && occupancy == DEPTH_V - 1'b1) full_sticky <= 1'b1;
    end

    // Show the oldest entry and the empty state.
    always_comb begin
        rd_data = mem[rd_ptr];
        empty   = (occupancy == '0);
    end
endmodule

// File: rtl/capture_logger.sv
// capture_logger: top of the timer-triggered capture logger. Connects the tick
// timer, the store gate and the capture queue.
// Assumes: rst_n is the observed bus reset, synchronous to clk and active low.
module capture_logger #(
    parameter int DATA_W  = capture_pkg::DEF_DATA_W,
    parameter int TAG_W   = capture_pkg::DEF_TAG_W,
    parameter int CNT_W   = capture_pkg::DEF_CNT_W,
    parameter int DEPTH   = capture_pkg::DEF_DEPTH,
    localparam int ENTRY_W = DATA_W + TAG_W,
    localparam int OCC_W   = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   trig_value,
    input  logic               skip_zero,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               rd_strobe,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               rd_empty,
    output logic [OCC_W-1:0]   occupancy,
    output logic               full_flag,
    output logic               capture_active
);
    logic               trig_hit, window_open, wr_en;
    logic [TAG_W-1:0]   stamp;
    logic [ENTRY_W-1:0] wr_entry;

    capture_timer #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_value  (trig_value),
        .trig_hit    (trig_hit),
        .window_open (window_open),
        .armed       (capture_active),
        .stamp       (stamp)
    );

    capture_gate #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ZERO_FILTER(1'b1)) u_gate (
        .in_valid      (in_valid),
        .in_data       (in_data),
        .skip_zero     (skip_zero),
        .window_open   (window_open),
        .store_blocked (full_flag),
        .stamp         (stamp),
        .wr_en         (wr_en),
        .wr_entry      (wr_entry)
    );

    capture_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_entry),
        .rd_strobe   (rd_strobe),
        .rd_data     (rd_data),
        .empty       (rd_empty),
        .occupancy   (occupancy),
        .full_sticky (full_flag)
    );
endmodule

// File: rtl/capture_logger_chk.sv
// capture_logger_chk: temporal checks on the capture logger, bound to its top.
module capture_logger_chk #(
    parameter int DATA_W = 32,
    parameter int OCC_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              skip_zero,
    input logic [DATA_W-1:0] in_data,
    input logic              rd_strobe,
    input logic [OCC_W-1:0]  occupancy,
    input logic              full_flag,
    input logic              capture_active,
    input logic              trig_hit,
    input logic              wr_en
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (occupancy == '0 && !full_flag && !capture_active));
    // R2
    early_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_active && !trig_hit) |-> !wr_en);
    // R5
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_active |=> capture_active);
    // R7
    zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_zero && in_data == '0) |-> !wr_en);
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && occupancy == '0 && !wr_en) |=> occupancy == '0);
    // R9
    occ_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_strobe && occupancy != '0) |=> $stable(occupancy));
    // R10
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag |=> full_flag);
    // R10
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag |-> !wr_en);
endmodule

bind capture_logger capture_logger_chk #(.DATA_W(DATA_W), .OCC_W(OCC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .skip_zero      (skip_zero),
    .in_data        (in_data),
    .rd_strobe      (rd_strobe),
    .occupancy      (occupancy),
    .full_flag      (full_flag),
    .capture_active (capture_active),
    .trig_hit       (trig_hit),
    .wr_en          (wr_en)
);

// File: tb/sim_capture_logger.sv
// sim_capture_logger: table-driven runs against a queue model, then directed cases.
module sim_capture_logger;
    localparam int DEPTH = 16;
    localparam int OCC_W = $clog2(DEPTH) + 1;
    localparam int NRUN  = 4;
    localparam logic [31:0] RUN_TRIG [NRUN] = '{32'd0, 32'd5, 32'd2, 32'd1000};
    localparam bit          RUN_SKIP [NRUN] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam int          RUN_LEN  [NRUN] = '{8, 14, 30, 20};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] trig_value = '0;
    logic        skip_zero = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        rd_strobe = 1'b0;
    logic [35:0] rd_data;
    logic        rd_empty, full_flag, capture_active;
    logic [OCC_W-1:0] occupancy;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Bench model of the requirements
    logic [35:0] exp_q[$];
    logic [31:0] cyc;
    logic [31:0] trig_m;
    bit          skip_m, armed_m, full_m;

    always #4 clk = ~clk;

    capture_logger #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_value(trig_value), .skip_zero(skip_zero),
        .in_valid(in_valid), .in_data(in_data), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rd_empty(rd_empty), .occupancy(occupancy),
        .full_flag(full_flag), .capture_active(capture_active)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [31:0] trig, input bit skip);
        trig_value = trig; skip_zero = skip; trig_m = trig; skip_m = skip;
        rst_n = 1'b0; in_valid = 1'b0; rd_strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = '0; armed_m = 1'b0; full_m = 1'b0;
        exp_q.delete();
    endtask

    // Drive one cycle from a negedge, update the model, return at the next negedge.
    task automatic step(input bit v, input logic [31:0] d, input bit rs);
        bit hit, wr;
        in_valid = v; in_data = d; rd_strobe = rs;
        hit = !armed_m && (cyc == trig_m);
        wr  = v && (armed_m || hit) && !(skip_m && d == 32'h0) && !full_m;
        if (rs && exp_q.size() > 0) void'(exp_q.pop_front());
        if (wr) begin
            exp_q.push_back({cyc[3:0], d});
            if (exp_q.size() == DEPTH) full_m = 1'b1;
        end
        if (hit) armed_m = 1'b1;
        @(posedge clk);
        cyc = cyc + 1;
        @(negedge clk);
        in_valid = 1'b0; rd_strobe = 1'b0;
    endtask

    function automatic logic [31:0] pattern(input int r, input int i);
        return (i % 3 == 0) ? 32'h0 : {8'hC3, 8'(r), 16'(i)};
    endfunction

    initial begin
        do_reset(32'd0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        // R1: reset state
        check("R1 occupancy", 64'(occupancy), 64'd0);
        check("R1 empty", 64'(rd_empty), 64'd1);
        check("R1 full_flag", 64'(full_flag), 64'd0);
        check("R1 capture_active", 64'(capture_active), 64'd0);

        // Table runs: R2 R3 R4 R6 R7 R10
        for (int r = 0; r < NRUN; r++) begin
            do_reset(RUN_TRIG[r], RUN_SKIP[r]);
            for (int i = 0; i < RUN_LEN[r]; i++) begin
                check("R3 capture_active timing", 64'(capture_active), 64'(armed_m));
                check("R9 occupancy", 64'(occupancy), 64'(exp_q.size()));
                step(1'b1, pattern(r, i), 1'b0);
            end
            check("R10 full_flag", 64'(full_flag), 64'(full_m));
            // R8 R6 R4 R7 R2: drain in order and compare each entry
            while (exp_q.size() > 0) begin
                check("R8 R6 entry", 64'(rd_data), 64'(exp_q[0]));
                step(1'b0, 32'h0, 1'b1);
            end
            check("R9 drained", 64'(occupancy), 64'd0);
            step(1'b0, 32'h0, 1'b1);
            check("R8 strobe on empty", 64'(occupancy), 64'd0);
            check("R10 flag after drain", 64'(full_flag), 64'(full_m));
            for (int k = 0; k < 3; k++) step(1'b1, 32'h0BAD_0001 + k, 1'b0);
            check("R10 R2 words after drain", 64'(occupancy), 64'(exp_q.size()));
        end

        // R9: write and pop in the same cycle
        do_reset(32'd0, 1'b0);
        step(1'b1, 32'h1111_0001, 1'b0);
        step(1'b1, 32'h1111_0002, 1'b0);
        check("R9 two stored", 64'(occupancy), 64'd2);
        step(1'b1, 32'h1111_0003, 1'b1);
        check("R9 write+pop keeps count", 64'(occupancy), 64'd2);
        check("R9 head after pop", 64'(rd_data), 64'({4'd1, 32'h1111_0002}));
        // R5: changing the trigger after it fired does not stop capture
        trig_value = 32'd500; trig_m = 32'd500;
        step(1'b1, 32'h1111_0004, 1'b0);
        check("R5 still active", 64'(capture_active), 64'd1);
        check("R5 still storing", 64'(occupancy), 64'd3);

        // R3 R4: trigger 0 captures the first word after reset
        do_reset(32'd0, 1'b1);
        check("R4 inactive before first edge", 64'(capture_active), 64'd0);
        step(1'b1, 32'hFEED_0000, 1'b0);
        check("R4 first word stored", 64'(occupancy), 64'd1);
        check("R6 stamp zero", 64'(rd_data), 64'({4'd0, 32'hFEED_0000}));
        check("R3 active after match", 64'(capture_active), 64'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule